// File: doc/BRIEF.md
# ESF Remote Alarm Detector

This block monitors the facility data link (FDL) of a T1 receiver running in extended superframe (ESF) mode and reports when the far end signals a remote alarm indication (RAI). The far end signals the alarm by sending a repeating 16-bit word on the FDL. The detector receives one FDL bit for each strobe cycle, locks onto the word boundary, and keeps a real-time alarm output. A separate sticky event bit records each new alarm for the host, and the host clears it by writing a one.

The detector has two ways of deciding. In direct mode, a run of consecutive aligned alarm words declares the alarm. The alarm drops when too few words in a window of slots match. In integration mode, that raw decision is filtered over a long window counted in millisecond ticks. The output then rides through dropouts of the alarm pattern, which a valid alarm may show for up to 100 ms at a time. Detection runs only while ESF mode is enabled.

The pattern tracker is a three-state machine. HUNT slides a window across every bit. HUNT goes to ARM when the window holds the alarm word. ARM counts aligned matches. ARM goes to ALARM on the last match of the run, and back to HUNT on the first aligned mismatch. ALARM evaluates aligned slots in windows. ALARM goes to HUNT when a window ends with too few matches, and otherwise stays in ALARM. The integration filter is a four-state machine. QUIET goes to SET_WAIT when the raw alarm appears. SET_WAIT goes to ACTIVE after the required ticks, or back to QUIET if the raw alarm vanishes. ACTIVE goes to CLR_WAIT when the raw alarm disappears. CLR_WAIT goes to QUIET after the required ticks, or back to ACTIVE if the raw alarm returns.

Top module: `rai_esf_monitor`

## Requirements
- R1: After reset, `rai_out` and `rai_evt` are 0.
- R2: The alarm word is 16 bits, first-received bit first: eight zeros, then eight ones (hex 00FF). It is recognised at any bit offset in the stream.
- R3: In direct mode (`integ_en`=0), `rai_out` rises once 16 consecutive word-aligned alarm words have been received. It rises within three clock cycles of the strobe that carries the last bit of the 16th word, and not before that strobe.
- R4: Before the alarm is declared, an aligned 16-bit word that is not the alarm word discards the run. Counting restarts from the next alarm word found at any offset.
- R5: While the alarm is declared, aligned words are counted in windows of 16 slots, starting at the declaration. At the end of a window in which 14 or fewer slots held the alarm word, `rai_out` falls. A window with 15 or 16 matches keeps the alarm.
- R6: In integration mode (`integ_en`=1), `rai_out` rises only after the raw direct-mode decision has been continuously active for more than `INTEG_MS` ticks. It rises on tick number `INTEG_MS`+1.
- R7: In integration mode, `rai_out` falls only after the raw decision has been continuously inactive for more than `INTEG_MS` ticks. It falls on tick number `INTEG_MS`+1.
- R8: Any change of the raw decision while a wait is in progress restarts that wait from zero ticks.
- R9: While `esf_en` is 0, `rai_out` is 0 from the next cycle. FDL bits are ignored, and both the pattern tracker and the filter return to their idle state.
- R10: `rai_evt` sets in the cycle after each rising edge of `rai_out`. It clears on `evt_clr`=1 unless a new rising edge arrives in the same cycle, and otherwise holds.
- R11: `fdl_bit` has no effect in cycles where `fdl_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| esf_en | input | 1 | ESF framing mode enable; detection runs only while 1 |
| integ_en | input | 1 | 1 selects the integration-filtered output, 0 the direct decision |
| fdl_valid | input | 1 | Strobe: `fdl_bit` carries one FDL bit this cycle |
| fdl_bit | input | 1 | FDL data bit |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| evt_clr | input | 1 | Host write of one that clears `rai_evt` |
| rai_out | output | 1 | Real-time remote alarm condition |
| rai_evt | output | 1 | Latched alarm-onset event |

## Verification
The bench keeps the 16-bit word, the run length of 16, the 16-slot window and the clear threshold of 14 at their defaults, so that direct-mode declaration and clearing are exercised with their real counts. It builds the block with `INTEG_MS`=4 instead of 200. With that value, the set and clear waits of the integration filter take five ticks each. Waits that are interrupted and restarted can then be driven tick by tick, and the boundary between tick four and tick five can be checked on both edges.

// File: rtl/rai_pkg.sv
package rai_pkg;

    // Pattern tracker states
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARM   = 2'd1,
        ST_ALARM = 2'd2
    } trk_state_e;

    // Integration filter states
    typedef enum logic [1:0] {
        IF_QUIET    = 2'd0,
        IF_SET_WAIT = 2'd1,
        IF_ACTIVE   = 2'd2,
        IF_CLR_WAIT = 2'd3
    } flt_state_e;

endpackage

// File: rtl/rai_align_fsm.sv
module rai_align_fsm
    import rai_pkg::*;
#(
    parameter int            PAT_W   = 16,
    parameter logic [PAT_W-1:0] PATTERN = 16'h00FF,
    parameter int            SET_RUN = 16,
    parameter int            WIN     = 16,
    parameter int            CLR_MAX = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic esf_en,
    input  logic fdl_valid,
    input  logic fdl_bit,
    output logic raw_alarm
);
    localparam int PH_W   = $clog2(PAT_W);
    localparam int RUN_W  = $clog2(SET_RUN + 1);
    localparam int SLOT_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int HIT_W  = $clog2(WIN + 1);

    trk_state_e        state_q, state_d;
    logic [PAT_W-1:0]  shreg_q, shreg_d;
    logic [PH_W-1:0]   phase_q, phase_d;
    logic [RUN_W-1:0]  run_q,   run_d;
    logic [SLOT_W-1:0] slot_q,  slot_d;
    logic [HIT_W-1:0]  hits_q,  hits_d;

    logic [PAT_W-1:0]  win;
    logic              match;
    logic              at_edge;
    logic [HIT_W-1:0]  total;

    assign win     = {shreg_q[PAT_W-2:0], fdl_bit};
    assign match   = (win == PATTERN);
    assign at_edge = (phase_q == PH_W'(PAT_W - 1));
    assign total   = hits_q + HIT_W'(match);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            shreg_q <= '0;
            phase_q <= '0;
            run_q   <= '0;
            slot_q  <= '0;
            hits_q  <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            phase_q <= phase_d;
            run_q   <= run_d;
            slot_q  <= slot_d;
            hits_q  <= hits_d;
        end
    end

    // Next state and counters
    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        phase_d = phase_q;
        run_d   = run_q;
        slot_d  = slot_q;
        hits_d  = hits_q;
        if (fdl_valid) begin
            shreg_d = win;
            unique case (state_q)
                ST_HUNT: begin
                    if (match) begin
                        state_d = ST_ARM;
                        run_d   = RUN_W'(1);
                        phase_d = '0;
                    end
                end
                ST_ARM: begin
                    if (at_edge) begin
                        phase_d = '0;
                        if (!match) begin
                            state_d = ST_HUNT;
                            run_d   = '0;
                        end else if (run_q == RUN_W'(SET_RUN - 1)) begin
                            state_d = ST_ALARM;
                            run_d   = '0;
                            slot_d  = '0;
                            hits_d  = '0;
                        end else begin
                            run_d = run_q + RUN_W'(1);
                        end
                    end else begin
                        phase_d = phase_q + PH_W'(1);
                    end
                end
                ST_ALARM: begin
                    if (at_edge) begin
                        phase_d = '0;
                        if (slot_q == SLOT_W'(WIN - 1)) begin
                            slot_d = '0;
                            hits_d = '0;
                            if (total <= HIT_W'(CLR_MAX)) begin
                                state_d = ST_HUNT;
                            end
                        end else begin
                            slot_d = slot_q + SLOT_W'(1);
                            hits_d = total;
                        end
                    end else begin
                        phase_d = phase_q + PH_W'(1);
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
        if (!esf_en) begin
            state_d = ST_HUNT;
            shreg_d = '0;
            phase_d = '0;
            run_d   = '0;
            slot_d  = '0;
            hits_d  = '0;
        end
    end

    // Output
    always_comb begin
        raw_alarm = (state_q == ST_ALARM);
    end

endmodule

// File: rtl/rai_integ_filter.sv
module rai_integ_filter
    import rai_pkg::*;
#(
    parameter int INTEG_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic esf_en,
    input  logic raw_alarm,
    input  logic tick_ms,
    output logic filt_alarm
);
    localparam int TMR_W = $clog2(INTEG_MS + 1);

    flt_state_e       state_q, state_d;
    logic [TMR_W-1:0] tmr_q,   tmr_d;
    logic             expired;

    assign expired = tick_ms && (tmr_q == TMR_W'(INTEG_MS));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IF_QUIET;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    // Next state and wait timer
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            IF_QUIET: begin
                tmr_d = '0;
                if (raw_alarm) state_d = IF_SET_WAIT;
            end
            IF_SET_WAIT: begin
                if (!raw_alarm) begin
                    state_d = IF_QUIET;
                    tmr_d   = '0;
                end else if (expired) begin
                    state_d = IF_ACTIVE;
                    tmr_d   = '0;
                end else if (tick_ms) begin
                    tmr_d = tmr_q + TMR_W'(1);
                end
            end
            IF_ACTIVE: begin
                tmr_d = '0;
                if (!raw_alarm) state_d = IF_CLR_WAIT;
            end
            IF_CLR_WAIT: begin
                if (raw_alarm) begin
                    state_d = IF_ACTIVE;
                    tmr_d   = '0;
                end else if (expired) begin
                    state_d = IF_QUIET;
                    tmr_d   = '0;
                end else if (tick_ms) begin
                    tmr_d = tmr_q + TMR_W'(1);
                end
            end
            default: begin
                state_d = IF_QUIET;
                tmr_d   = '0;
            end
        endcase
        if (!esf_en) begin
            state_d = IF_QUIET;
            tmr_d   = '0;
        end
    end

    // Output
    always_comb begin
        filt_alarm = (state_q == IF_ACTIVE) || (state_q == IF_CLR_WAIT);
    end

endmodule

// File: rtl/rai_evt_latch.sv
module rai_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm,
    input  logic clr,
    output logic evt
);
    logic prev_q;
    logic onset;

    assign onset = alarm && !prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            evt    <= 1'b0;
        end else begin
            prev_q <= alarm;
            if (onset)    evt <= 1'b1;
            else if (clr) evt <= 1'b0;
        end
    end

endmodule

// File: rtl/rai_esf_monitor.sv
module rai_esf_monitor #(
    parameter int               PAT_W    = 16,
    parameter logic [PAT_W-1:0] PATTERN  = 16'h00FF,
    parameter int               SET_RUN  = 16,
    parameter int               WIN      = 16,
    parameter int               CLR_MAX  = 14,
    parameter int               INTEG_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic esf_en,
    input  logic integ_en,
    input  logic fdl_valid,
    input  logic fdl_bit,
    input  logic tick_ms,
    input  logic evt_clr,
    output logic rai_out,
    output logic rai_evt
);
    logic raw_alarm;
    logic filt_alarm;

    rai_align_fsm #(
        .PAT_W  (PAT_W),
        .PATTERN(PATTERN),
        .SET_RUN(SET_RUN),
        .WIN    (WIN),
        .CLR_MAX(CLR_MAX)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .esf_en   (esf_en),
        .fdl_valid(fdl_valid),
        .fdl_bit  (fdl_bit),
        .raw_alarm(raw_alarm)
    );

    rai_integ_filter #(
        .INTEG_MS(INTEG_MS)
    ) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .esf_en    (esf_en),
        .raw_alarm (raw_alarm),
        .tick_ms   (tick_ms),
        .filt_alarm(filt_alarm)
    );

    // Output mode select register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rai_out <= 1'b0;
        else if (!esf_en) rai_out <= 1'b0;
        else              rai_out <= integ_en ? filt_alarm : raw_alarm;
    end

    rai_evt_latch u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .alarm(rai_out),
        .clr  (evt_clr),
        .evt  (rai_evt)
    );

endmodule

// File: rtl/rai_esf_monitor_chk.sv
module rai_esf_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic esf_en,
    input logic integ_en,
    input logic fdl_valid,
    input logic tick_ms,
    input logic evt_clr,
    input logic rai_out,
    input logic rai_evt
);
    a_r9_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        !esf_en |=> !rai_out);

    a_r10_evt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rai_out) |=> rai_evt);

    a_r10_evt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !$rose(rai_out)) |=> !rai_evt);

    a_r10_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rai_evt && !evt_clr) |=> rai_evt);

    a_r3_rise_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rai_out) && !$past(integ_en)) |-> $past(fdl_valid, 2));

    a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rai_out) && $past(integ_en) && $past(integ_en, 2)) |-> $past(tick_ms, 2));

endmodule

bind rai_esf_monitor rai_esf_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .esf_en   (esf_en),
    .integ_en (integ_en),
    .fdl_valid(fdl_valid),
    .tick_ms  (tick_ms),
    .evt_clr  (evt_clr),
    .rai_out  (rai_out),
    .rai_evt  (rai_evt)
);

// File: tb/sim_rai_esf_monitor.sv
`timescale 1ns/1ps
module sim_rai_esf_monitor;
    localparam int INTEG = 4;
    localparam logic [15:0] GOOD = 16'h00FF;
    localparam logic [15:0] BAD  = 16'hFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic esf_en = 1'b0;
    logic integ_en = 1'b0;
    logic fdl_valid = 1'b0;
    logic fdl_bit = 1'b0;
    logic tick_ms = 1'b0;
    logic evt_clr = 1'b0;
    logic rai_out;
    logic rai_evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench reference model of the direct decision
    logic [15:0] m_win = '0;
    int m_mode = 0;   // 0 search, 1 counting run, 2 alarm
    int m_pos = 0;
    int m_good = 0;
    int m_slots = 0;
    int m_miss = 0;

    always #4 clk = ~clk;

    rai_esf_monitor #(.INTEG_MS(INTEG)) u0 (
        .clk(clk), .rst_n(rst_n), .esf_en(esf_en), .integ_en(integ_en),
        .fdl_valid(fdl_valid), .fdl_bit(fdl_bit), .tick_ms(tick_ms),
        .evt_clr(evt_clr), .rai_out(rai_out), .rai_evt(rai_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit is_alarm_word(input logic [15:0] w);
        return w == 16'h00FF;
    endfunction

    task automatic model_reset();
        m_win = '0; m_mode = 0; m_pos = 0; m_good = 0; m_slots = 0; m_miss = 0;
    endtask

    task automatic model_bit(input logic b);
        bit hit;
        m_win = {m_win[14:0], b};
        hit = is_alarm_word(m_win);
        if (m_mode == 0) begin
            if (hit) begin m_mode = 1; m_good = 1; m_pos = 0; end
        end else begin
            m_pos++;
            if (m_pos == 16) begin
                m_pos = 0;
                if (m_mode == 1) begin
                    if (!hit) begin m_mode = 0; m_good = 0; end
                    else begin
                        m_good++;
                        if (m_good == 16) begin m_mode = 2; m_slots = 0; m_miss = 0; end
                    end
                end else begin
                    m_slots++;
                    if (!hit) m_miss++;
                    if (m_slots == 16) begin
                        if (16 - m_miss <= 14) m_mode = 0;
                        m_slots = 0; m_miss = 0;
                    end
                end
            end
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        fdl_valid = 1'b1; fdl_bit = b;
        @(negedge clk);
        fdl_valid = 1'b0; fdl_bit = 1'($urandom);  // R11: ignored bit value
        @(negedge clk);
        @(negedge clk);
        if (esf_en) model_bit(b);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic esf_cycle();
        @(negedge clk); esf_en = 1'b0;
        @(negedge clk); @(negedge clk);
        esf_en = 1'b1;
        model_reset();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check("R1 rai_out in reset", int'(rai_out), 0);
        check("R1 rai_evt in reset", int'(rai_evt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        esf_en = 1'b1;
        @(negedge clk);
        check("R1 rai_out after reset", int'(rai_out), 0);
        check("R1 rai_evt after reset", int'(rai_evt), 0);

        // R2/R3: off-byte alignment, declaration on the last bit of word 16
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        for (int k = 0; k < 15; k++) send_word(GOOD);
        check("R3 no alarm after 15 words", int'(rai_out), 0);
        for (int i = 15; i >= 1; i--) send_bit(GOOD[i]);
        check("R3 no alarm before final bit", int'(rai_out), 0);
        send_bit(GOOD[0]);
        check("R2 R3 alarm after 16th word at odd offset", int'(rai_out), 1);
        check("R10 event set on onset", int'(rai_evt), 1);
        pulse_clr();
        check("R10 event cleared by write", int'(rai_evt), 0);
        repeat (4) @(negedge clk);
        check("R10 event stays clear while alarm holds", int'(rai_evt), 0);

        // R5: one miss keeps, two misses clear at window end
        for (int k = 0; k < 16; k++) send_word(k == 5 ? BAD : GOOD);
        check("R5 one miss keeps alarm", int'(rai_out), 1);
        for (int k = 0; k < 15; k++) send_word((k == 3 || k == 9) ? BAD : GOOD);
        check("R5 alarm kept until window end", int'(rai_out), 1);
        send_word(GOOD);
        check("R5 two misses clear alarm", int'(rai_out), 0);

        // R4: broken run restarts
        for (int k = 0; k < 10; k++) send_word(GOOD);
        send_word(BAD);
        for (int k = 0; k < 15; k++) send_word(GOOD);
        check("R4 run discarded by a miss", int'(rai_out), 0);
        send_word(GOOD);
        check("R4 alarm after fresh 16 run", int'(rai_out), 1);
        pulse_clr();

        // R9: disable forces low and ignores stream
        @(negedge clk); esf_en = 1'b0;
        @(negedge clk);
        check("R9 disable forces low", int'(rai_out), 0);
        for (int k = 0; k < 18; k++) send_word(GOOD);
        check("R9 stream ignored while disabled", int'(rai_out), 0);
        @(negedge clk); esf_en = 1'b1; model_reset();
        send_word(GOOD);
        check("R9 detection restarts after enable", int'(rai_out), 0);
        check("R10 no event while disabled", int'(rai_evt), 0);
        esf_cycle();

        // R6/R7/R8: integration filter with INTEG_MS=4
        integ_en = 1'b1;
        for (int k = 0; k < 16; k++) send_word(GOOD);
        check("R6 raw alarm not yet passed", int'(rai_out), 0);
        send_ticks(INTEG);
        check("R6 still low after INTEG_MS ticks", int'(rai_out), 0);
        send_ticks(1);
        check("R6 rises on tick INTEG_MS+1", int'(rai_out), 1);
        for (int k = 0; k < 16; k++) send_word((k == 2 || k == 7) ? BAD : GOOD);
        check("R7 filtered alarm rides through raw drop", int'(rai_out), 1);
        send_ticks(3);
        check("R7 still high during clear wait", int'(rai_out), 1);
        for (int k = 0; k < 16; k++) send_word(GOOD);
        for (int k = 0; k < 16; k++) send_word((k == 1 || k == 12) ? BAD : GOOD);
        send_ticks(INTEG);
        check("R8 clear wait restarted", int'(rai_out), 1);
        send_ticks(1);
        check("R7 falls on tick INTEG_MS+1", int'(rai_out), 0);
        integ_en = 1'b0;
        esf_cycle();
        pulse_clr();

        // Random streams in direct mode against the bench model (R2 R3 R4 R5 R11)
        for (int w = 0; w < 160; w++) begin
            logic [15:0] word;
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 88) word = GOOD;
            else if (r < 94) word = BAD;
            else word = 16'($urandom);
            if ($urandom_range(0, 14) == 0) begin
                int extra;
                extra = int'($urandom_range(1, 3));
                for (int e = 0; e < extra; e++) begin
                    send_bit(1'($urandom));
                    check("R2 random offset bit", int'(rai_out), (m_mode == 2) ? 1 : 0);
                end
            end
            for (int i = 15; i >= 0; i--) begin
                send_bit(word[i]);
                check("R3 R4 R5 R11 random stream", int'(rai_out), (m_mode == 2) ? 1 : 0);
            end
        end
        finish_run();
    end

endmodule